// File: doc/BRIEF.md
# Framed Serial DAC Register Interface

This block is the digital slave front end of an eight-channel DAC. It receives 16-bit words over a three-wire serial link. The link has an active-low frame select, a serial clock and a data line. The three link signals and the active-low load strobe are brought into the system clock domain by a two-stage synchronizer. The system clock must run at least four times as fast as the serial clock. Falling serial-clock edges are detected from the synchronized copies.

A frame starts when frame select goes low. Bits are taken MSB first on each falling serial edge, and the word is committed on the 16th falling edge. A frame that ends early is dropped. Edges after the 16th are ignored until frame select returns high. A committed data word is written into one channel's input register. The active-low load strobe copies all eight input registers into the DAC registers, which drive the converters. If the strobe is tied low, the DAC registers follow the input registers.

The framing state machine has three states:
- `FR_IDLE`: waiting for frame select to go low.
- `FR_SHIFT`: collecting bits.
- `FR_HOLD`: word committed, further edges ignored.

It has five transitions:
- `FR_IDLE` to `FR_SHIFT` on frame select low.
- `FR_SHIFT` to `FR_IDLE` on an early frame end.
- `FR_SHIFT` to `FR_HOLD` on the 16th falling edge.
- `FR_HOLD` to `FR_IDLE` on frame select high.
- Every state to `FR_IDLE` on reset.

Top module: `serial_dac_frontend`

## Requirements
- R1: An asynchronous active-low reset clears all eight input and DAC registers to zero and holds `frame_done_o` low.
- R2: A word is shifted in MSB first. Bit 15 is the flag, where 0 means data. Bits 14:12 select the channel, with 0 = A through 7 = H. Bits 11:0 are the data. On the 16th falling edge, a data word writes its 12-bit data into the addressed channel's input register.
- R3: If frame select goes high before the 16th falling edge, the partial word is discarded. No register changes and no `frame_done_o` pulse occurs.
- R4: Falling serial edges after the 16th in the same frame are ignored.
- R5: A committed word with bit 15 = 1 changes no input register but still produces a `frame_done_o` pulse.
- R6: `frame_done_o` is a single-cycle pulse. It is high after the third rising system edge, counting as the first the edge that first samples the 16th serial-clock low.
- R7: While the synchronized load strobe is low, all eight DAC registers copy their input registers on the same edge. While it is high, the DAC registers hold.
- R8: With the load strobe held low, a channel's DAC output shows a new word one system cycle after that channel's input register is written. That is one edge after `frame_done_o` falls.
- R9: Serial clock edges while frame select is high change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n_i | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock; data taken on falling edges |
| sdata_i | input | 1 | Serial data, MSB first |
| load_n_i | input | 1 | Active-low load strobe |
| dac_o | output | 96 | Eight 12-bit DAC register values; channel c at bits [c*12 +: 12] |
| frame_done_o | output | 1 | One-cycle pulse per committed frame |

## Verification
Every input passes two synchronizer flops. This fixes the latency of each result:
- A falling serial edge acts on the third system edge after it is first sampled. That edge raises `frame_done_o`.
- The input register is written one edge later.
- The DAC register follows one edge after that when the load strobe is low. A load strobe by itself reaches the DAC registers on the third edge.

The bench keeps a per-cycle history of the sampled inputs and steps a behavioural model at every rising edge using those delays. It compares the outputs to the model at the following falling edge. Scenario checks are taken only after each frame or strobe has fully settled.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    typedef enum logic [1:0] {
        FR_IDLE  = 2'd0,
        FR_SHIFT = 2'd1,
        FR_HOLD  = 2'd2
    } fr_state_e;

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[0] <= RST_VAL;
                else        stg[0] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter
    import dacfe_pkg::*;
#(
    parameter int WORD = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frm_hi_i,
    input  logic            sck_i,
    input  logic            sdi_i,
    output logic [WORD-1:0] word_o,
    output logic            commit_o
);

    localparam int            CW   = $clog2(WORD);
    localparam logic [CW-1:0] LAST = CW'(WORD - 1);

    fr_state_e       state, state_nx;
    logic [CW-1:0]   cnt;
    logic [WORD-1:0] sh;
    logic            sck_prev;
    logic            fall;
    logic            take;
    logic            last_bit;

    assign fall     = sck_prev && !sck_i;
    assign take     = (state == FR_SHIFT) && !frm_hi_i && fall;
    assign last_bit = take && (cnt == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FR_IDLE;
        else        state <= state_nx;
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            FR_IDLE:  if (!frm_hi_i) state_nx = FR_SHIFT;
            FR_SHIFT: begin
                if (frm_hi_i)      state_nx = FR_IDLE;
                else if (last_bit) state_nx = FR_HOLD;
            end
            FR_HOLD:  if (frm_hi_i) state_nx = FR_IDLE;
            default:  state_nx = FR_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_prev <= 1'b1;
            cnt      <= '0;
            sh       <= '0;
            word_o   <= '0;
            commit_o <= 1'b0;
        end else begin
            sck_prev <= sck_i;
            commit_o <= last_bit;
            if (state == FR_IDLE) begin
                cnt <= '0;
            end else if (take) begin
                sh  <= {sh[WORD-2:0], sdi_i};
                cnt <= cnt + 1'b1;
            end
            if (last_bit) word_o <= {sh[WORD-2:0], sdi_i};
        end
    end

    a_r3_early_end_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_SHIFT && frm_hi_i) |=> (state == FR_IDLE && !commit_o));
    a_r4_hold_ignores_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_HOLD) |=> !commit_o);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);
    a_r9_idle_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_IDLE) |=> !commit_o);

endmodule

// File: rtl/dacfe_bank.sv
module dacfe_bank #(
    parameter int NCH = 8,
    parameter int DW  = 12,
    parameter int AW  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            commit_i,
    input  logic            flag_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   data_i,
    input  logic            load_low_i,
    output logic [NCH*DW-1:0] dac_o
);

    logic [NCH*DW-1:0] in_flat;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                in_flat[c*DW +: DW] <= '0;
            end else if (commit_i && !flag_i && (addr_i == AW'(c))) begin
                in_flat[c*DW +: DW] <= data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          dac_o[c*DW +: DW] <= '0;
            else if (load_low_i) dac_o[c*DW +: DW] <= in_flat[c*DW +: DW];
        end

        a_r2_addressed_write: assert property (@(posedge clk) disable iff (!rst_n)
            (commit_i && !flag_i && addr_i == AW'(c)) |=> (in_flat[c*DW +: DW] == $past(data_i)));
    end

    a_r5_ctrl_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && flag_i) |=> $stable(in_flat));
    a_r7_hold_when_high: assert property (@(posedge clk) disable iff (!rst_n)
        !load_low_i |=> $stable(dac_o));
    a_r8_follow_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        load_low_i |=> (dac_o == $past(in_flat)));

endmodule

// File: rtl/serial_dac_frontend.sv
module serial_dac_frontend #(
    parameter int NCH         = 8,
    parameter int WORD        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_n_i,
    input  logic                 sclk_i,
    input  logic                 sdata_i,
    input  logic                 load_n_i,
    output logic [NCH*(WORD-1-$clog2(NCH))-1:0] dac_o,
    output logic                 frame_done_o
);

    localparam int AW = $clog2(NCH);
    localparam int DW = WORD - 1 - AW;

    logic [3:0]      raw, syn;
    logic [WORD-1:0] word;

    assign raw = {load_n_i, sdata_i, sclk_i, frame_n_i};

    dacfe_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1011)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    dacfe_shifter #(
        .WORD (WORD)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_hi_i (syn[0]),
        .sck_i    (syn[1]),
        .sdi_i    (syn[2]),
        .word_o   (word),
        .commit_o (frame_done_o)
    );

    dacfe_bank #(
        .NCH (NCH),
        .DW  (DW),
        .AW  (AW)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (frame_done_o),
        .flag_i     (word[WORD-1]),
        .addr_i     (word[WORD-2 -: AW]),
        .data_i     (word[DW-1:0]),
        .load_low_i (!syn[3]),
        .dac_o      (dac_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_clear: assert (frame_done_o == 1'b0);
        end
    end

endmodule

// File: tb/test_serial_dac_frontend.sv
module test_serial_dac_frontend;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdata = 1'b0;
    logic        load_n = 1'b1;
    logic [95:0] dac;
    logic        done;

    int n_cmp = 0;
    int n_bad = 0;
    int n_done = 0;

    always #2 clk = ~clk;

    serial_dac_frontend i_serial_dac_frontend (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_n_i    (frame_n),
        .sclk_i       (sclk),
        .sdata_i      (sdata),
        .load_n_i     (load_n),
        .dac_o        (dac),
        .frame_done_o (done)
    );

    // behavioural reference model
    int   m_state, m_cnt, m_word, m_sh;
    bit   m_commit;
    int   m_in  [8];
    int   m_dac [8];
    bit   hf[1:3], hs[1:3], hd[1:3], hl[1:3];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_word = 0; m_sh = 0; m_commit = 0;
            foreach (m_in[i]) begin m_in[i] = 0; m_dac[i] = 0; end
            for (int k = 1; k <= 3; k++) begin
                hf[k] = 1; hs[k] = 1; hd[k] = 0; hl[k] = 1;
            end
        end else begin
            if (!hl[2]) foreach (m_dac[i]) m_dac[i] = m_in[i];
            if (m_commit && !m_word[15]) m_in[(m_word >> 12) & 7] = m_word & 12'hFFF;
            m_commit = 0;
            case (m_state)
                0: begin
                    m_cnt = 0;
                    if (!hf[2]) m_state = 1;
                end
                1: begin
                    if (hf[2]) m_state = 0;
                    else if (hs[3] && !hs[2]) begin
                        m_sh = ((m_sh << 1) | int'(hd[2])) & 16'hFFFF;
                        m_cnt++;
                        if (m_cnt == 16) begin
                            m_commit = 1; m_word = m_sh; m_state = 2;
                        end
                    end
                end
                default: if (hf[2]) m_state = 0;
            endcase
            hf[3] = hf[2]; hf[2] = hf[1]; hf[1] = frame_n;
            hs[3] = hs[2]; hs[2] = hs[1]; hs[1] = sclk;
            hd[3] = hd[2]; hd[2] = hd[1]; hd[1] = sdata;
            hl[3] = hl[2]; hl[2] = hl[1]; hl[1] = load_n;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (done !== m_commit) begin
                n_bad++;
                $display("FAIL R6 cycle compare frame_done actual=%0b expected=%0b", done, m_commit);
            end
            for (int c = 0; c < 8; c++) begin
                n_cmp++;
                if (dac[c*12 +: 12] !== 12'(m_dac[c])) begin
                    n_bad++;
                    $display("FAIL R7 cycle compare ch%0d actual=%h expected=%h",
                             c, dac[c*12 +: 12], m_dac[c]);
                end
            end
            if (done) n_done++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ch(input int c);
        return int'(dac[c*12 +: 12]);
    endfunction

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [15:0] w, input int nbits, input int extra);
        frame_n = 1'b0;
        wclk(4);
        for (int b = 0; b < nbits + extra; b++) begin
            sdata = (b < 16) ? w[15-b] : 1'b1;
            wclk(4);
            sclk = 1'b0;
            wclk(4);
            sclk = 1'b1;
        end
        wclk(4);
        frame_n = 1'b1;
        wclk(12);
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wclk(4);
        load_n = 1'b1;
        wclk(8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wclk(3);
        for (int c = 0; c < 8; c++) check("R1 reset dac", ch(c), 0);
        check("R1 reset frame_done", int'(done), 0);
        rst_n = 1'b1;
        wclk(5);

        // R2 / R7: write while load high, outputs hold
        send(16'h2ABC, 16, 0);
        check("R7 hold while load high ch2", ch(2), 0);
        check("R6 one pulse per frame", n_done, 1);
        send(16'h5123, 16, 0);
        send(16'h7FFF, 16, 0);
        send(16'h0001, 16, 0);
        pulse_load();
        check("R2 ch2 data", ch(2), 'hABC);
        check("R2 ch5 data", ch(5), 'h123);
        check("R2 ch7 data", ch(7), 'hFFF);
        check("R2 ch0 data", ch(0), 'h001);
        check("R7 untouched ch1", ch(1), 0);

        // R3: early frame end
        send(16'h3555, 15, 0);
        pulse_load();
        check("R3 aborted frame ch3", ch(3), 0);
        check("R3 no pulse on abort", n_done, 4);

        // R4: extra edges ignored
        send(16'h4AAA, 16, 4);
        pulse_load();
        check("R4 extra edges ch4", ch(4), 'hAAA);
        check("R4 single pulse", n_done, 5);

        // R5: control word
        send(16'hC777, 16, 0);
        pulse_load();
        check("R5 control word ch4 kept", ch(4), 'hAAA);
        check("R5 control pulse", n_done, 6);

        // R9: clock edges with frame select high
        for (int b = 0; b < 20; b++) begin
            sdata = 1'b1; wclk(4); sclk = 1'b0; wclk(4); sclk = 1'b1;
        end
        pulse_load();
        check("R9 idle edges no pulse", n_done, 6);
        check("R9 idle edges ch7", ch(7), 'hFFF);

        // R8: load tied low
        load_n = 1'b0;
        wclk(8);
        send(16'h6456, 16, 0);
        check("R8 follow ch6", ch(6), 'h456);
        send(16'h1F0F, 16, 0);
        check("R8 follow ch1", ch(1), 'hF0F);
        load_n = 1'b1;
        wclk(8);

        // R1: reset mid-run
        rst_n = 1'b0;
        wclk(2);
        for (int c = 0; c < 8; c++) check("R1 reset clears dac", ch(c), 0);
        rst_n = 1'b1;
        wclk(4);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule